// File: doc/BRIEF.md
# Pointer-list descriptor DMA engine

A single-channel memory-to-memory copier controlled through a two-level chain. Software writes one command word naming a list of 32-bit pointers. The engine walks that list in order. Each pointer leads to an array of four-word copy descriptors. The engine runs each descriptor as an ascending word-by-word copy. On the way, it can swap adjacent bytes, adjacent halfwords or adjacent words. Each swap can be chosen for the source side, the destination side, or both.

When the whole chain finishes, the engine posts one result word into a small queue. The same happens when the chain is aborted by a malformed command. Software pops results through a register read. An interrupt stays raised while a result is pending, if it is enabled.

Registers are reached through a plain write/read port. Accesses are 32-bit, and `reg_addr` is the word index:
- 0: command pointer (write).
- 1: result (read pops).
- 2: status (read).
- 3: configuration (read/write).

Memory is reached through a valid/ready request stream and a valid/ready read-response stream:
- A request offered with `mem_req_valid` stays unchanged until `mem_req_ready` is high at a clock edge.
- A read response is taken on an edge where `mem_rsp_valid` and `mem_rsp_ready` are both high.
- The engine never has more than one access in flight.

Top module: `ptr_dma_engine`

## Requirements
- R1: A command-pointer write carries a type code in bits 31:29 and a list address shifted right by 3 in bits 28:0. Type 1 starts a pointer-list walk at the address `bits[28:0] << 3`. Any other type posts an error result and makes no memory access.
- R2: The pointer list is read in ascending 4-byte steps. In each entry, bit 31 marks the last pointer and bits 28:0 hold the descriptor-array address shifted right by 3.
- R3: A descriptor is four consecutive words at +0, +4, +8 and +12: command, source byte address, destination byte address, byte length. Command bit 31 marks the last descriptor of its array. Otherwise the next descriptor follows at +16. After a last descriptor, the engine goes to the next pointer, or finishes if that pointer was the last one.
- R4: Command bits 1:0 give the mode. Only 0 is executed. A nonzero mode posts an error result and aborts the chain with no further memory writes. Copies finished earlier in the chain remain.
- R5: The byte length is rounded up to whole words. Words are copied from ascending source addresses to ascending destination addresses. A zero length writes nothing. No word beyond the rounded length is written.
- R6: Source swaps use command bits 11 (adjacent bytes), 12 (adjacent halfwords) and 13 (adjacent words). Destination swaps use bits 14, 15 and 16 with the same meanings. A swap chosen on both sides cancels. The word swap exchanges the two words of each 8-byte beat counted from the descriptor's first word. A trailing lone word is not word-swapped.
- R7: A result word has bit 31 = valid, bit 3 = error, bit 2 = flush (always 0) and bit 1 = done. All other bits are 0. A completed chain gives 0x80000002. An aborted one gives 0x80000008.
- R8: Results enter a 4-deep first-in first-out queue. Reading register 1 returns the oldest result and removes it. An empty queue reads as 0. With the queue full, the engine holds its result and stays busy until a pop frees a slot. A push and a pop may share one cycle.
- R9: Status (register 2) holds:
  - bits 31:29: queued result count;
  - bits 28:27: command count, 1 while a chain is running;
  - bit 1: result valid;
  - bit 0: ready for a command pointer.
  All other bits are 0. After reset it reads 0x00000001.
- R10: Configuration bit 0 enables the interrupt. `irq` is high exactly when that bit is set and the queue is not empty. Configuration resets to 0.
- R11: A command-pointer write while status bit 0 is low is ignored.
- R12: A memory request stays stable until accepted. No request is offered while a read response is awaited.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops on the result address) |
| reg_addr | input | 2 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| mem_req_valid | output | 1 | Memory request offered |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_we | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | 32 | Byte address, word aligned |
| mem_req_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_ready | output | 1 | Engine awaits read data |
| mem_rsp_data | input | 32 | Read data |
| irq | output | 1 | Result-pending interrupt |

## Verification
Two functions can meet in one cycle: the engine pushing its final result and software popping the result register. The bench provokes this as follows:
- It fills the queue with four results without reading.
- It starts a fifth chain, which stalls with the queue full.
- It then pops one result.

In that cycle the held result enters the slot being freed. The bench judges this by four checks:
- The popped value is the oldest entry.
- The count stays at four.
- The engine returns to ready.
- Exactly four results drain before the queue reads empty.

// File: rtl/ptr_dma_pkg.sv
package ptr_dma_pkg;

  localparam int DW = 32;

  // command-pointer type code for a pointer-list walk
  localparam logic [2:0] TYPE_PTR_LIST = 3'd1;

  // register word indices
  localparam logic [1:0] RA_CMDPTR = 2'd0;
  localparam logic [1:0] RA_RESULT = 2'd1;
  localparam logic [1:0] RA_STATUS = 2'd2;
  localparam logic [1:0] RA_CONFIG = 2'd3;

  // result word bit positions
  localparam int RB_VALID = 31;
  localparam int RB_ERROR = 3;
  localparam int RB_FLUSH = 2;
  localparam int RB_DONE  = 1;

  typedef enum logic [2:0] {
    S_IDLE,
    S_PTR,
    S_DESC,
    S_RD_A,
    S_RD_B,
    S_WR_A,
    S_WR_B,
    S_POST
  } seq_state_e;

  function automatic logic [DW-1:0] swap_bytes(input logic [DW-1:0] w);
    return {w[23:16], w[31:24], w[7:0], w[15:8]};
  endfunction

  function automatic logic [DW-1:0] swap_halves(input logic [DW-1:0] w);
    return {w[15:0], w[31:16]};
  endfunction

endpackage

// File: rtl/ptr_dma_swap_stage.sv
module ptr_dma_swap_stage
  import ptr_dma_pkg::*;
(
  input  logic [DW-1:0] in_a,
  input  logic [DW-1:0] in_b,
  input  logic          pair,
  input  logic          sw_byte,
  input  logic          sw_half,
  input  logic          sw_word,
  output logic [DW-1:0] out_a,
  output logic [DW-1:0] out_b
);

  logic [DW-1:0] a1, b1, a2, b2;

  always_comb begin
    a1 = sw_byte ? swap_bytes(in_a) : in_a;
    b1 = sw_byte ? swap_bytes(in_b) : in_b;
    a2 = sw_half ? swap_halves(a1) : a1;
    b2 = sw_half ? swap_halves(b1) : b1;
    if (sw_word && pair) begin
      out_a = b2;
      out_b = a2;
    end else begin
      out_a = a2;
      out_b = b2;
    end
  end

endmodule

// File: rtl/ptr_dma_rsltq.sv
module ptr_dma_rsltq #(
  parameter int DEPTH = 4,
  parameter int W     = 32,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [CW-1:0] count,
  output logic          can_push
);

  logic [W-1:0]  slots [DEPTH];
  logic [PW-1:0] wptr, rptr;
  logic          pop_ok, push_ok;

  assign pop_ok   = pop && (count != '0);
  assign can_push = (count != CW'(DEPTH)) || pop_ok;
  assign push_ok  = push && can_push;
  assign head     = (count == '0) ? '0 : slots[rptr];

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push_ok) wptr <= bump(wptr);
      if (pop_ok)  rptr <= bump(rptr);
      if (push_ok && !pop_ok)      count <= count + CW'(1);
      else if (pop_ok && !push_ok) count <= count - CW'(1);
    end
  end

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      always_ff @(posedge clk) begin
        if (push_ok && wptr == PW'(g)) slots[g] <= push_data;
      end
    end
  endgenerate

endmodule

// File: rtl/ptr_dma_seq.sv
module ptr_dma_seq
  import ptr_dma_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [DW-1:0] start_word,
  output logic          idle,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic          mem_req_we,
  output logic [DW-1:0] mem_req_addr,
  output logic [DW-1:0] mem_req_wdata,
  input  logic          mem_rsp_valid,
  output logic          mem_rsp_ready,
  input  logic [DW-1:0] mem_rsp_data,
  output logic [DW-1:0] beat_a,
  output logic [DW-1:0] beat_b,
  output logic          beat_pair,
  output logic [5:0]    swap_sel,
  input  logic [DW-1:0] swapped_a,
  input  logic [DW-1:0] swapped_b,
  output logic          post_valid,
  output logic [DW-1:0] post_word,
  input  logic          post_accept
);

  localparam int RW = DW - 1;

  seq_state_e    state;
  logic [DW-1:0] ptr_addr, desc_addr, src_ptr, dst_ptr;
  logic [1:0]    widx;
  logic          last_ptr, d_last, post_err, wait_rsp;
  logic [1:0]    d_mode;
  logic [RW-1:0] remain, step, nwords;
  logic          is_read, is_write, rd_done, wr_done;
  seq_state_e    after_desc;

  assign is_read  = (state == S_PTR) || (state == S_DESC) ||
                    (state == S_RD_A) || (state == S_RD_B);
  assign is_write = (state == S_WR_A) || (state == S_WR_B);
  assign rd_done  = is_read && wait_rsp && mem_rsp_valid;
  assign wr_done  = is_write && mem_req_ready;

  assign idle          = (state == S_IDLE);
  assign mem_req_valid = (is_read && !wait_rsp) || is_write;
  assign mem_req_we    = is_write;
  assign mem_rsp_ready = wait_rsp;
  assign beat_pair     = (remain > RW'(1));
  assign step          = beat_pair ? RW'(2) : RW'(1);
  assign nwords        = RW'(mem_rsp_data[31:2]) + RW'(|mem_rsp_data[1:0]);
  assign after_desc    = !d_last ? S_DESC : (last_ptr ? S_POST : S_PTR);

  always_comb begin
    unique case (state)
      S_PTR:   mem_req_addr = ptr_addr;
      S_DESC:  mem_req_addr = desc_addr + {28'd0, widx, 2'b00};
      S_RD_A:  mem_req_addr = src_ptr;
      S_RD_B:  mem_req_addr = src_ptr + 32'd4;
      S_WR_A:  mem_req_addr = dst_ptr;
      S_WR_B:  mem_req_addr = dst_ptr + 32'd4;
      default: mem_req_addr = '0;
    endcase
    mem_req_wdata = (state == S_WR_B) ? swapped_b : swapped_a;
  end

  always_comb begin
    post_valid = (state == S_POST);
    post_word  = '0;
    post_word[RB_VALID] = 1'b1;
    post_word[RB_ERROR] = post_err;
    post_word[RB_FLUSH] = 1'b0;
    post_word[RB_DONE]  = !post_err;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      ptr_addr  <= '0;
      desc_addr <= '0;
      src_ptr   <= '0;
      dst_ptr   <= '0;
      widx      <= '0;
      last_ptr  <= 1'b0;
      d_last    <= 1'b0;
      d_mode    <= '0;
      swap_sel  <= '0;
      post_err  <= 1'b0;
      wait_rsp  <= 1'b0;
      remain    <= '0;
      beat_a    <= '0;
      beat_b    <= '0;
    end else begin
      if (is_read && !wait_rsp && mem_req_ready) wait_rsp <= 1'b1;
      if (rd_done) wait_rsp <= 1'b0;

      unique case (state)
        S_IDLE: begin
          if (start) begin
            if (start_word[31:29] == TYPE_PTR_LIST) begin
              ptr_addr <= {start_word[28:0], 3'b000};
              post_err <= 1'b0;
              state    <= S_PTR;
            end else begin
              post_err <= 1'b1;
              state    <= S_POST;
            end
          end
        end
        S_PTR: begin
          if (rd_done) begin
            last_ptr  <= mem_rsp_data[31];
            desc_addr <= {mem_rsp_data[28:0], 3'b000};
            ptr_addr  <= ptr_addr + 32'd4;
            widx      <= '0;
            state     <= S_DESC;
          end
        end
        S_DESC: begin
          if (rd_done) begin
            widx <= widx + 2'd1;
            unique case (widx)
              2'd0: begin
                d_last   <= mem_rsp_data[31];
                d_mode   <= mem_rsp_data[1:0];
                swap_sel <= mem_rsp_data[16:11];
              end
              2'd1: src_ptr <= mem_rsp_data;
              2'd2: dst_ptr <= mem_rsp_data;
              default: begin
                desc_addr <= desc_addr + 32'd16;
                remain    <= nwords;
                if (d_mode != 2'd0) begin
                  post_err <= 1'b1;
                  state    <= S_POST;
                end else if (nwords == '0) begin
                  state <= after_desc;
                end else begin
                  state <= S_RD_A;
                end
              end
            endcase
          end
        end
        S_RD_A: begin
          if (rd_done) begin
            beat_a <= mem_rsp_data;
            beat_b <= '0;
            state  <= beat_pair ? S_RD_B : S_WR_A;
          end
        end
        S_RD_B: begin
          if (rd_done) begin
            beat_b <= mem_rsp_data;
            state  <= S_WR_A;
          end
        end
        S_WR_A, S_WR_B: begin
          if (wr_done) begin
            if (state == S_WR_A && beat_pair) begin
              state <= S_WR_B;
            end else begin
              src_ptr <= src_ptr + 32'd8;
              dst_ptr <= dst_ptr + 32'd8;
              remain  <= remain - step;
              state   <= (remain == step) ? after_desc : S_RD_A;
            end
          end
        end
        S_POST: begin
          if (post_accept) state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/ptr_dma_engine.sv
module ptr_dma_engine
  import ptr_dma_pkg::*;
#(
  parameter int RQ_DEPTH = 4,
  localparam int CW      = $clog2(RQ_DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [1:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic          mem_req_we,
  output logic [31:0]   mem_req_addr,
  output logic [31:0]   mem_req_wdata,
  input  logic          mem_rsp_valid,
  output logic          mem_rsp_ready,
  input  logic [31:0]   mem_rsp_data,
  output logic          irq
);

  logic          cmd_ready, start, cfg_irq_en;
  logic          rq_pop, rq_push, rq_can_push, post_valid;
  logic [DW-1:0] post_word, rq_head;
  logic [CW-1:0] rq_cnt;
  logic [DW-1:0] beat_a, beat_b, swapped_a, swapped_b;
  logic          beat_pair;
  logic [5:0]    swap_sel;
  logic [31:0]   status_word;

  assign start   = reg_wr && (reg_addr == RA_CMDPTR) && cmd_ready;
  assign rq_pop  = reg_rd && (reg_addr == RA_RESULT);
  assign rq_push = post_valid && rq_can_push;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_irq_en <= 1'b0;
    else if (reg_wr && reg_addr == RA_CONFIG) cfg_irq_en <= reg_wdata[0];
  end

  ptr_dma_seq u_seq (
    .clk, .rst_n, .start, .start_word(reg_wdata), .idle(cmd_ready),
    .mem_req_valid, .mem_req_ready, .mem_req_we, .mem_req_addr, .mem_req_wdata,
    .mem_rsp_valid, .mem_rsp_ready, .mem_rsp_data,
    .beat_a, .beat_b, .beat_pair, .swap_sel, .swapped_a, .swapped_b,
    .post_valid, .post_word, .post_accept(rq_can_push)
  );

  // source stage then destination stage
  logic [DW-1:0] chain_a [3];
  logic [DW-1:0] chain_b [3];
  assign chain_a[0] = beat_a;
  assign chain_b[0] = beat_b;

  generate
    for (genvar s = 0; s < 2; s++) begin : g_side
      ptr_dma_swap_stage u_stage (
        .in_a(chain_a[s]), .in_b(chain_b[s]), .pair(beat_pair),
        .sw_byte(swap_sel[3*s]), .sw_half(swap_sel[3*s+1]), .sw_word(swap_sel[3*s+2]),
        .out_a(chain_a[s+1]), .out_b(chain_b[s+1])
      );
    end
  endgenerate

  assign swapped_a = chain_a[2];
  assign swapped_b = chain_b[2];

  ptr_dma_rsltq #(.DEPTH(RQ_DEPTH), .W(DW)) u_rq (
    .clk, .rst_n, .push(post_valid), .push_data(post_word), .pop(rq_pop),
    .head(rq_head), .count(rq_cnt), .can_push(rq_can_push)
  );

  always_comb begin
    status_word        = '0;
    status_word[31:29] = 3'(rq_cnt);
    status_word[28:27] = {1'b0, !cmd_ready};
    status_word[1]     = (rq_cnt != '0);
    status_word[0]     = cmd_ready;
  end

  always_comb begin
    unique case (reg_addr)
      RA_RESULT: reg_rdata = rq_head;
      RA_STATUS: reg_rdata = status_word;
      RA_CONFIG: reg_rdata = {31'd0, cfg_irq_en};
      default:   reg_rdata = '0;
    endcase
  end

  assign irq = cfg_irq_en && (rq_cnt != '0);

endmodule

// File: rtl/ptr_dma_chk.sv
module ptr_dma_chk #(
  parameter int DEPTH = 4,
  parameter int CW    = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_req_valid,
  input logic          mem_req_ready,
  input logic          mem_req_we,
  input logic [31:0]   mem_req_addr,
  input logic [31:0]   mem_req_wdata,
  input logic          mem_rsp_ready,
  input logic          cmd_ready,
  input logic          irq,
  input logic          cfg_irq_en,
  input logic [CW-1:0] rq_cnt,
  input logic          rq_pop,
  input logic          rq_push
);

  p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we) && $stable(mem_req_wdata)));

  p_one_outstanding_r12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rsp_ready |-> !mem_req_valid);

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !mem_req_valid);

  p_irq_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (cfg_irq_en && rq_cnt != '0));

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rq_cnt <= CW'(DEPTH));

  p_pop_dec_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rq_pop && rq_cnt != '0 && !rq_push) |=> (rq_cnt == $past(rq_cnt) - CW'(1)));

endmodule

bind ptr_dma_engine ptr_dma_chk #(.DEPTH(RQ_DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
  .mem_rsp_ready(mem_rsp_ready), .cmd_ready(cmd_ready), .irq(irq), .cfg_irq_en(cfg_irq_en),
  .rq_cnt(rq_cnt), .rq_pop(rq_pop), .rq_push(rq_push)
);

// File: tb/ptr_dma_engine_tb.sv
`timescale 1ns/1ps
module ptr_dma_engine_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        mem_req_valid, mem_req_ready, mem_req_we, mem_rsp_ready, irq;
  logic [31:0] mem_req_addr, mem_req_wdata;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic [7:0]  lfsr = 8'h5A;
  logic [31:0] mem [256];
  int          n_cmp = 0, n_err = 0;
  logic        finished = 1'b0;

  always #2.5 clk = ~clk;

  ptr_dma_engine u_dut (.*);

  // memory model: random back-pressure, one-cycle read latency
  assign mem_req_ready = lfsr[0] | lfsr[2];
  always @(posedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    if (mem_rsp_valid && mem_rsp_ready) mem_rsp_valid <= 1'b0;
    if (mem_req_valid && mem_req_ready) begin
      if (mem_req_we) mem[mem_req_addr[9:2]] <= mem_req_wdata;
      else begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_data  <= mem[mem_req_addr[9:2]];
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 4000; i++) begin
      reg_read(2'd2, s);
      if (s[0]) return;
    end
  endtask

  function automatic logic [31:0] pat(input int j, input int k);
    return (32'(j) * 32'h01000193) ^ (32'(k) * 32'h9E3779B9) ^ 32'h0F1E2D3C;
  endfunction

  function automatic logic [31:0] bsw(input logic [31:0] w);
    return {w[23:16], w[31:24], w[7:0], w[15:8]};
  endfunction

  function automatic logic [31:0] hsw(input logic [31:0] w);
    return {w[15:0], w[31:16]};
  endfunction

  // R6: effective swap is the exclusive-or of the two sides
  function automatic logic [31:0] exp_word(input int j, input int i, input int nw, input logic [5:0] m);
    logic [2:0] e;
    int k;
    logic [31:0] w;
    e = m[2:0] ^ m[5:3];
    k = ((((i & ~1) + 1) < nw) && e[2]) ? (i ^ 1) : i;
    w = pat(j, k);
    if (e[0]) w = bsw(w);
    if (e[1]) w = hsw(w);
    return w;
  endfunction

  task automatic prep(input int j);
    for (int k = 0; k < 16; k++) mem[64 + k] = pat(j, k);
    for (int k = 0; k < 32; k++) mem[128 + k] = 32'hDEAD0000 | 32'(k);
  endtask

  // one pointer (last) -> array at 0x40 with a single descriptor, src 0x100, dst 0x200
  task automatic run_single(input int j, input logic [31:0] cmd, input logic [31:0] len);
    @(negedge clk);
    prep(j);
    mem[0]  = 32'h80000008;
    mem[16] = cmd; mem[17] = 32'h100; mem[18] = 32'h200; mem[19] = len;
    reg_write(2'd0, 32'h20000000);
  endtask

  logic [31:0] v;
  int nw;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset state
    reg_read(2'd2, v); chk("R9 status after reset", v, 32'h00000001);
    reg_read(2'd1, v); chk("R8 empty result read", v, 32'h0);
    reg_read(2'd3, v); chk("R10 config reset", v, 32'h0);
    chk("R10 irq after reset", {31'd0, irq}, 32'h0);
    chk("R12 no request after reset", {31'd0, mem_req_valid}, 32'h0);

    // sweep all swap selections against several lengths
    for (int m = 0; m < 64; m++) begin
      for (int li = 0; li < 4; li++) begin
        int lens[4] = '{1, 4, 8, 13};
        int j = m * 4 + li;
        run_single(j, 32'h80000000 | (32'(m) << 11), 32'(lens[li]));
        wait_idle();
        reg_read(2'd1, v); chk("R7 done result", v, 32'h80000002);
        nw = (lens[li] + 3) / 4;
        for (int i = 0; i < nw; i++)
          chk($sformatf("R6 R5 word %0d swap %0d len %0d", i, m, lens[li]),
              mem[128 + i], exp_word(j, i, nw, 6'(m)));
        chk("R5 guard past length", mem[128 + nw], 32'hDEAD0000 | 32'(nw));
      end
    end

    // zero length
    run_single(300, 32'h80000000, 32'd0);
    wait_idle();
    reg_read(2'd1, v); chk("R5 zero length done", v, 32'h80000002);
    chk("R5 zero length no write", mem[128], 32'hDEAD0000);

    // unsupported types
    reg_write(2'd0, 32'h40000000);
    wait_idle();
    reg_read(2'd1, v); chk("R1 type 2 error", v, 32'h80000008);
    reg_write(2'd0, 32'h00000000);
    wait_idle();
    reg_read(2'd1, v); chk("R1 type 0 error", v, 32'h80000008);
    chk("R1 no write on bad type", mem[128], 32'hDEAD0000);

    // unsupported mode in a single descriptor
    run_single(301, 32'h80000001, 32'd8);
    wait_idle();
    reg_read(2'd1, v); chk("R4 mode error", v, 32'h80000008);
    chk("R4 no write on bad mode", mem[128], 32'hDEAD0000);

    // two-level chain: two pointers, first array two descriptors
    for (int pass = 0; pass < 2; pass++) begin
      @(negedge clk);
      prep(400);
      mem[0]  = 32'h00000008; mem[1] = 32'h80000010;
      mem[16] = 32'h0;        mem[17] = 32'h100; mem[18] = 32'h200; mem[19] = 32'd8;
      mem[20] = (pass == 0) ? 32'h80000000 : 32'h80000002;
      mem[21] = 32'h108; mem[22] = 32'h220; mem[23] = 32'd4;
      mem[32] = 32'h80000800; mem[33] = 32'h10C; mem[34] = 32'h240; mem[35] = 32'd12;
      reg_write(2'd0, 32'h20000000);
      wait_idle();
      reg_read(2'd1, v);
      chk("R3 chain first copy w0", mem[128], pat(400, 0));
      chk("R3 chain first copy w1", mem[129], pat(400, 1));
      chk("R5 chain guard", mem[130], 32'hDEAD0002);
      if (pass == 0) begin
        chk("R2 chain done", v, 32'h80000002);
        chk("R3 second descriptor", mem[136], pat(400, 2));
        for (int i = 0; i < 3; i++)
          chk("R2 second pointer copy", mem[144 + i], bsw(pat(400, 3 + i)));
        chk("R2 second pointer guard", mem[147], 32'hDEAD0013);
      end else begin
        chk("R4 chain abort error", v, 32'h80000008);
        chk("R4 aborted descriptor not written", mem[136], 32'hDEAD0008);
        chk("R4 later pointer not run", mem[144], 32'hDEAD0010);
      end
    end

    // command write while busy is ignored
    run_single(500, 32'h80000000, 32'd36);
    reg_write(2'd0, 32'h40000000);
    wait_idle();
    reg_read(2'd2, v); chk("R11 one result after busy write", v, 32'h20000003);
    reg_read(2'd1, v); chk("R11 result is done", v, 32'h80000002);

    // queue fill, interrupt gating, push and pop in the same cycle
    for (int q = 0; q < 4; q++) begin
      run_single(600 + q, 32'h80000000, 32'd4);
      wait_idle();
    end
    chk("R10 irq disabled", {31'd0, irq}, 32'h0);
    reg_write(2'd3, 32'h1);
    reg_read(2'd3, v); chk("R10 config readback", v, 32'h1);
    chk("R10 irq enabled with pending", {31'd0, irq}, 32'h1);
    run_single(610, 32'h80000000, 32'd4);
    repeat (200) @(negedge clk);
    reg_read(2'd2, v); chk("R8 engine held while full", v, 32'h88000002);
    reg_read(2'd1, v); chk("R8 pop during push", v, 32'h80000002);
    reg_read(2'd2, v); chk("R8 count kept after shared cycle", v, 32'h80000003);
    for (int q = 0; q < 4; q++) begin
      reg_read(2'd1, v); chk("R8 drain", v, 32'h80000002);
    end
    reg_read(2'd1, v); chk("R8 empty after drain", v, 32'h0);
    chk("R10 irq clear when empty", {31'd0, irq}, 32'h0);
    reg_read(2'd2, v); chk("R9 status idle empty", v, 32'h00000001);

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_err++;
      $display("FAIL R12 watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
      $finish;
    end
  end

endmodule